// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block is a synthesizable stand-in for the serial read-out side of a sampling converter. It lets a host controller be tested against realistic framing without any analog parts. A host pulls an active-low start strobe low to request a conversion. It then toggles a serial clock, and the model shifts out a word taken from a parallel sample input, preceded by a fixed number of zero bits. The output is modelled as a data bit plus a separate output-enable bit.

Both host inputs are asynchronous to the model's system clock. The model synchronises them and detects their edges. Where the strobe returns high, counted in serial-clock rising edges since the frame began, decides two things: whether the port stays in normal operation or drops into a partial power-down state, and when the output stops driving. A flag marks the first conversion after reset, which is the calibration conversion.

Top module: `adc_serial_port_model`

## Requirements
- R1: A falling strobe edge latches `sample_in`, sets `sdo_oe` to 1 with `sdo` at 0, and sets `pwr_low` to 0.
- R2: During a frame, rising serial-clock edges 1 to 3 keep `sdo` at 0. Edges 4 to 15 drive the sample bits from bit 11 (MSB) down to bit 0, one bit per edge. Edge 16 drives 0.
- R3: `sdo_oe` is 0 after reset and at all times outside a frame.
- R4: If the strobe rises after the 14th or 15th rising edge, the frame keeps shifting, `pwr_low` stays 0, and the next falling strobe edge starts a normal conversion.
- R5: If the strobe rises when 3 to 13 rising edges have been counted, `pwr_low` becomes 1 and `sdo_oe` becomes 0 without waiting for another serial-clock edge.
- R6: Once 16 rising edges are counted, `sdo_oe` falls on the first of these: the 16th edge arriving while the strobe is already high, the strobe rising, or a 17th rising edge.
- R7: `cal_flag` is 1 from the first falling strobe edge after reset until the next falling strobe edge. It is never 1 again, including after a wake from power-down.
- R8: A falling strobe edge during power-down clears `pwr_low` and starts a normal frame.
- R9: If the strobe rises when fewer than 3 rising edges have been counted, the frame ends with `sdo_oe` at 0 and `pwr_low` unchanged at 0.
- R10: Serial-clock edges outside a frame have no effect. Each response appears at the third system-clock edge after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_n | input | 1 | Active-low start strobe, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sample_in | input | 12 | Parallel word to be shifted out |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | 1 while the port drives `sdo`; 0 models high impedance |
| pwr_low | output | 1 | 1 in partial power-down, 0 in normal operation |
| cal_flag | output | 1 | 1 during the calibration conversion |

## Verification
The hardest cases to reach are the strobe rising on either side of each window boundary: after exactly 2, 3, 13, 14 and 16 counted edges. The other hard case is a strobe held low past the 16th edge until a 17th edge arrives. The bench reaches these with a frame task that takes the edge count at which the strobe rises and the total number of clock edges. It holds every input level long enough for the synchroniser to settle, so each boundary is hit exactly. A behavioural model updated at each host event is compared with the outputs on every settled clock.

// File: rtl/adc_serial_port_model.sv
module adc_serial_port_model #(
  parameter int DATA_W = 12,
  parameter int LEAD_Z = 3,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              pwr_low,
  output logic              cal_flag
);
  localparam int FRAME = LEAD_Z + DATA_W + 1;
  localparam int CNT_W = $clog2(FRAME + 2);
  localparam logic [CNT_W-1:0] L_LEADZ = CNT_W'(LEAD_Z);
  localparam logic [CNT_W-1:0] L_FRAME = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] L_CONT  = CNT_W'(FRAME - 2);

  logic [SYNC:0]       cnv_pipe, sck_pipe;
  logic                cnv_s, cnv_fall, cnv_rise, sck_rise;
  logic                active, first_done;
  logic [CNT_W-1:0]    cnt, cnt_nx;
  logic [DATA_W-1:0]   shreg;

  assign cnv_s    = cnv_pipe[SYNC-1];
  assign cnv_fall = cnv_pipe[SYNC] & ~cnv_s;
  assign cnv_rise = ~cnv_pipe[SYNC] & cnv_s;
  assign sck_rise = ~sck_pipe[SYNC] & sck_pipe[SYNC-1];
  assign cnt_nx   = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_pipe <= '1;
      sck_pipe <= '0;
    end else begin
      cnv_pipe <= {cnv_pipe[SYNC-1:0], cnv_n};
      sck_pipe <= {sck_pipe[SYNC-1:0], sclk};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      first_done <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      sdo        <= 1'b0;
      sdo_oe     <= 1'b0;
      pwr_low    <= 1'b0;
      cal_flag   <= 1'b0;
    end else if (cnv_fall) begin
      active     <= 1'b1;
      cnt        <= '0;
      shreg      <= sample_in;
      sdo        <= 1'b0;
      sdo_oe     <= 1'b1;
      pwr_low    <= 1'b0;
      cal_flag   <= ~first_done;
      first_done <= 1'b1;
    end else if (cnv_rise && active) begin
      if (cnt < L_LEADZ || cnt >= L_FRAME) begin
        active <= 1'b0;
        sdo_oe <= 1'b0;
      end else if (cnt < L_CONT) begin
        active  <= 1'b0;
        sdo_oe  <= 1'b0;
        pwr_low <= 1'b1;
      end
    end else if (sck_rise && active) begin
      cnt <= cnt_nx;
      if (cnt_nx > L_FRAME || (cnt_nx == L_FRAME && cnv_s)) begin
        active <= 1'b0;
        sdo_oe <= 1'b0;
        sdo    <= 1'b0;
      end else if (cnt_nx > L_LEADZ && cnt_nx < L_FRAME) begin
        sdo   <= shreg[DATA_W-1];
        shreg <= {shreg[DATA_W-2:0], 1'b0};
      end else begin
        sdo <= 1'b0;
      end
    end
  end
endmodule

module adc_serial_port_model_chk #(
  parameter int LEAD_Z = 3,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             pwr_low,
  input logic             cal_flag,
  input logic             active,
  input logic             cnv_fall,
  input logic [CNT_W-1:0] cnt
);
  logic cal_over;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_over <= 1'b0;
    else if (cal_flag) cal_over <= 1'b1;
  end

  AST_FALL_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_fall |=> (sdo_oe && !sdo && !pwr_low)); // R1
  AST_LEAD_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && cnt <= CNT_W'(LEAD_Z)) |-> !sdo); // R2
  AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> active); // R3
  AST_PD_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_low |-> !sdo_oe); // R5
  AST_CAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_over && !cal_flag) |=> !cal_flag); // R7
endmodule

bind adc_serial_port_model adc_serial_port_model_chk #(.LEAD_Z(LEAD_Z), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .pwr_low(pwr_low),
  .cal_flag(cal_flag), .active(active), .cnv_fall(cnv_fall), .cnt(cnt)
);

// File: tb/adc_serial_port_model_bench.sv
module adc_serial_port_model_bench;
  localparam int DW = 12;
  localparam int LZ = 3;
  localparam int FR = LZ + DW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv_n = 1'b1;
  logic sclk = 1'b0;
  logic [DW-1:0] sample = '0;
  logic sdo, sdo_oe, pwr_low, cal_flag;

  always #10 clk = ~clk;

  adc_serial_port_model u_adc_serial_port_model (
    .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .sclk(sclk), .sample_in(sample),
    .sdo(sdo), .sdo_oe(sdo_oe), .pwr_low(pwr_low), .cal_flag(cal_flag)
  );

  int n_tests = 0;
  int n_fail = 0;
  int settle = 0;
  bit done = 0;

  // behavioural reference state
  bit m_active = 0, m_oe = 0, m_dout = 0, m_pd = 0, m_cal = 0, m_first = 0;
  int m_cnt = 0;
  logic [DW-1:0] m_samp = '0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic void m_fall();
    m_active = 1; m_oe = 1; m_dout = 0; m_cnt = 0; m_samp = sample;
    m_pd = 0; m_cal = !m_first; m_first = 1;
  endfunction

  function automatic void m_rise();
    if (!m_active) return;
    if (m_cnt < LZ || m_cnt >= FR) begin m_active = 0; m_oe = 0; end
    else if (m_cnt < FR - 2) begin m_active = 0; m_oe = 0; m_pd = 1; end
  endfunction

  function automatic void m_sclk();
    if (!m_active) return;
    m_cnt++;
    if (m_cnt > FR || (m_cnt == FR && cnv_n)) begin m_active = 0; m_oe = 0; m_dout = 0; end
    else if (m_cnt > LZ && m_cnt < FR) m_dout = m_samp[DW + LZ - m_cnt];
    else m_dout = 0;
  endfunction

  always @(posedge clk) settle = settle + 1;

  always @(negedge clk) begin
    if (rst_n && !done && settle >= 4) begin
      chk("R3 oe", sdo_oe, m_oe);
      chk("R5 pwr_low", pwr_low, m_pd);
      chk("R7 cal_flag", cal_flag, m_cal);
      if (m_oe) chk("R2 sdo", sdo, m_dout);
    end
  end

  task automatic hold();
    repeat (6) @(posedge clk);
    #2;
  endtask

  task automatic drive_cnv(input bit v);
    if (!v && cnv_n) m_fall();
    else if (v && !cnv_n) m_rise();
    cnv_n = v; settle = 0;
    hold();
  endtask

  task automatic pulse();
    m_sclk();
    sclk = 1'b1; settle = 0; hold();
    sclk = 1'b0; settle = 0; hold();
  endtask

  task automatic frame(input logic [DW-1:0] s, input int rise_at, input int edges);
    sample = s;
    drive_cnv(0);
    for (int i = 1; i <= edges; i++) begin
      pulse();
      if (i == rise_at) drive_cnv(1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1; settle = 0;
    hold();
    chk("R3 reset oe", sdo_oe, 0);
    chk("R5 reset pwr_low", pwr_low, 0);
    chk("R7 reset cal", cal_flag, 0);

    // R10: serial clock while idle does nothing
    for (int i = 0; i < 5; i++) pulse();
    chk("R10 idle oe", sdo_oe, 0);

    // calibration frame, strobe up between 15th and 16th edge
    sample = 12'hA5C;
    drive_cnv(0);
    chk("R1 fall oe", sdo_oe, 1);
    chk("R1 fall sdo", sdo, 0);
    chk("R7 first cal", cal_flag, 1);
    for (int i = 1; i <= 16; i++) begin
      pulse();
      if (i == 4) chk("R2 msb", sdo, 1);
      if (i == 15) begin chk("R2 lsb", sdo, 0); drive_cnv(1); end
    end
    chk("R6 oe off at 16th with strobe high", sdo_oe, 0);
    chk("R4 still normal", pwr_low, 0);

    // strobe held low past 16: off on 17th edge
    frame(12'h3F1, 0, 16);
    chk("R7 second cal", cal_flag, 0);
    chk("R6 oe held after 16", sdo_oe, 1);
    pulse();
    chk("R6 oe off on 17th", sdo_oe, 0);
    drive_cnv(1);

    // partial power-down, then wake
    frame(12'h5A5, 8, 8);
    chk("R5 pd entered", pwr_low, 1);
    chk("R5 pd oe", sdo_oe, 0);
    pulse();
    chk("R10 pd sclk ignored", sdo_oe, 0);
    frame(12'hFFF, 14, 16);
    chk("R8 wake pwr", pwr_low, 0);
    chk("R7 no cal after wake", cal_flag, 0);
    chk("R4 normal after 14", pwr_low, 0);

    // strobe low past 16 then rises before a 17th edge
    frame(12'h0F0, 0, 16);
    drive_cnv(1);
    chk("R6 oe off on rise", sdo_oe, 0);
    chk("R6 pwr", pwr_low, 0);

    // early abort and window boundaries
    frame(12'h123, 2, 2);
    chk("R9 abort oe", sdo_oe, 0);
    chk("R9 abort pwr", pwr_low, 0);
    frame(12'h456, 3, 3);
    chk("R5 boundary 3", pwr_low, 1);
    frame(12'h789, 13, 13);
    chk("R5 boundary 13", pwr_low, 1);
    frame(12'h800, 14, 16);
    chk("R4 boundary 14", pwr_low, 0);
    frame(12'h001, 16, 16);
    chk("R6 done", sdo_oe, 0);

    hold();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule